// File: doc/BRIEF.md
# Memory Controller Configuration Register Bank

This block holds the software-visible setup of an external memory controller. Software reaches it through a plain 32-bit word read/write port. The words it holds are a global control word, a read-only power-on strap word and a base-address mask. Each chip select also has a configuration word and a timing word, and the bank presents all of them in parallel to the chip-select decode logic. The memory-device signalling and refresh sit outside this block.

The power-on strap input is sampled while reset is held. Chip select 0 leaves reset already enabled, with its memory type and bus width taken from the strap and a timing word chosen by that memory type, so boot memory can be reached without any software setup. Every register write that could change address decode raises a one-cycle update strobe for each chip select it touches, so the downstream decoder knows when to recompute.

Top module: `mem_cfg_regs`

## Requirements
- R1: Word map, with `addr_i[1:0]` ignored: control at byte 0x00, strap at 0x04, mask at 0x08. Chip select i has its configuration word at 0x10+8*i and its timing word at 0x14+8*i, for i in 0..NUM_CS-1. A read (`req_i`=1, `we_i`=0) returns the addressed word on `rdata_o` in the same cycle.
- R2: The control word is fully writable, reads back as written and drives `ctrl_o`. A write appears there after the write's clock edge.
- R3: The strap word holds the value of `poc_i` at the release of `rst_ni`. Later changes on `poc_i` and bus writes to 0x04 leave it unchanged.
- R4: A write to the mask keeps only the bits set in MASK_VALID (default 0x000000FF). All other bits read as zero and drive zero on `mask_o`.
- R5: Reset clears the control word, the mask, the update strobes and every configuration and timing word of chip selects 1..NUM_CS-1.
- R6: After reset, chip select 0's configuration word is strap[1:0] in bits [5:4] (bus width), {0,strap[3:2]} in bits [3:1] (memory type), 1 in bit 0 (enable), and zero elsewhere.
- R7: After reset, chip select 0's timing word depends on the memory type: type 0 (asynchronous) gives 0x03FFFFFF, type 1 (SDRAM) gives 0x0F200230, type 2 (synchronous burst SRAM) gives 0xFFFFFFFF and type 3 (generic synchronous) gives 0x00003A5F.
- R8: A write to a chip-select word changes only that word. It appears on lane i (bits [32*i+31:32*i]) of `csc_o` or `tms_o` after the write's clock edge.
- R9: A write to an address outside the map (0x0C, or 0x10+8*NUM_CS and above) changes no register and raises no strobe. A read there returns zero.
- R10: `upd_o[i]` is high for exactly the one cycle after a write to chip select i's configuration or timing word. After a mask write every bit is high for that one cycle. It stays low for all other accesses.
- R11: `rdata_o` is zero whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poc_i | input | 32 | Power-on strap word, sampled while reset is held |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| ctrl_o | output | 32 | Control word |
| mask_o | output | 32 | Base-address mask |
| csc_o | output | 32*NUM_CS | Configuration word per chip select |
| tms_o | output | 32*NUM_CS | Timing word per chip select |
| upd_o | output | NUM_CS | Per-chip-select update strobe |

## Verification
The embedded assertions check these on every cycle: the address decode selects at most one word, each chip-select word either takes the written data or holds, the mask never carries bits outside its valid set, the strap word ignores writes, and the update strobes follow the write class of the previous cycle. The strap-dependent boot values for all four memory types can only be shown by the bench's scenarios. The same holds for the full map walk with `addr_i[1:0]` ignored, the out-of-range holes, and the independence of chip-select lanes. The bench resets repeatedly with different straps and compares every output against its model on every cycle.

// File: rtl/mem_cfg_pkg.sv
`timescale 1ns/1ps
package mem_cfg_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    MT_ASYNC = 3'd0,
    MT_SDRAM = 3'd1,
    MT_SSRAM = 3'd2,
    MT_SYNC  = 3'd3
  } mem_type_e;

  // configuration word fields
  localparam int unsigned CSC_EN_BIT   = 0;
  localparam int unsigned CSC_TYPE_LSB = 1;
  localparam int unsigned CSC_TYPE_W   = 3;
  localparam int unsigned CSC_BW_LSB   = 4;
  localparam int unsigned CSC_BW_W     = 2;
  localparam int unsigned CSC_SEL_LSB  = 16;
  localparam int unsigned CSC_SEL_W    = 8;

  // word indices of the fixed registers and first pair
  localparam int unsigned WIDX_CTRL = 0;
  localparam int unsigned WIDX_POC  = 1;
  localparam int unsigned WIDX_MASK = 2;
  localparam int unsigned WIDX_PAIR = 4;

  localparam logic [WORD_W-1:0] TMS_DEF_ASYNC = 32'h03FF_FFFF;
  localparam logic [WORD_W-1:0] TMS_DEF_SDRAM = 32'h0F20_0230;
  localparam logic [WORD_W-1:0] TMS_DEF_SSRAM = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] TMS_DEF_SYNC  = 32'h0000_3A5F;

  function automatic logic [WORD_W-1:0] boot_csc(logic [3:0] strap);
    logic [WORD_W-1:0] v;
    v = '0;
    v[CSC_TYPE_LSB +: CSC_TYPE_W] = {1'b0, strap[3:2]};
    v[CSC_BW_LSB +: CSC_BW_W]     = strap[1:0];
    v[CSC_EN_BIT]                 = 1'b1;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] boot_tms(logic [3:0] strap);
    mem_type_e t;
    t = mem_type_e'({1'b0, strap[3:2]});
    case (t)
      MT_ASYNC: return TMS_DEF_ASYNC;
      MT_SDRAM: return TMS_DEF_SDRAM;
      MT_SSRAM: return TMS_DEF_SSRAM;
      default:  return TMS_DEF_SYNC;
    endcase
  endfunction

endpackage

// File: rtl/mem_cfg_decode.sv
`timescale 1ns/1ps
module mem_cfg_decode
  import mem_cfg_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned NUM_CS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AW-1:0]     addr_i,
  output logic              sel_ctrl_o,
  output logic              sel_poc_o,
  output logic              sel_mask_o,
  output logic [NUM_CS-1:0] sel_csc_o,
  output logic [NUM_CS-1:0] sel_tms_o,
  output logic              hit_o
);

  localparam int unsigned WIDX_W   = AW - 2;
  localparam int unsigned CS_IDX_W = WIDX_W - 1;
  localparam logic [WIDX_W-1:0] PAIR_LO = WIDX_W'(WIDX_PAIR);
  localparam logic [WIDX_W-1:0] PAIR_HI = WIDX_W'(WIDX_PAIR + 2 * NUM_CS);

  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] rel;
  logic              in_pairs;
  logic [1:0]        unused_lsb;

  assign widx       = addr_i[AW-1:2];
  assign unused_lsb = addr_i[1:0];
  assign rel        = widx - PAIR_LO;
  assign in_pairs   = (widx >= PAIR_LO) && (widx < PAIR_HI);

  assign sel_ctrl_o = req_i && (widx == WIDX_W'(WIDX_CTRL));
  assign sel_poc_o  = req_i && (widx == WIDX_W'(WIDX_POC));
  assign sel_mask_o = req_i && (widx == WIDX_W'(WIDX_MASK));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs_sel
    logic slot_hit;
    assign slot_hit     = req_i && in_pairs && (rel[WIDX_W-1:1] == CS_IDX_W'(i));
    assign sel_csc_o[i] = slot_hit && !rel[0];
    assign sel_tms_o[i] = slot_hit &&  rel[0];
  end

  assign hit_o = sel_ctrl_o | sel_poc_o | sel_mask_o | (|sel_csc_o) | (|sel_tms_o);

  // R1: at most one word selected per access
  assert_one_select_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_ctrl_o, sel_poc_o, sel_mask_o, sel_csc_o, sel_tms_o}));

  // R9: no selection without a request
  assert_idle_no_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !hit_o);

endmodule

// File: rtl/mem_cfg_cs_slot.sv
`timescale 1ns/1ps
module mem_cfg_cs_slot
  import mem_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] rst_csc_i,
  input  logic [WORD_W-1:0] rst_tms_i,
  input  logic              wr_csc_i,
  input  logic              wr_tms_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] csc_o,
  output logic [WORD_W-1:0] tms_o
);

  logic [WORD_W-1:0] csc_q, tms_q;

  // reset value is a strap-derived constant for slot 0, zero otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csc_q <= rst_csc_i;
      tms_q <= rst_tms_i;
    end else begin
      if (wr_csc_i) csc_q <= wdata_i;
      if (wr_tms_i) tms_q <= wdata_i;
    end
  end

  assign csc_o = csc_q;
  assign tms_o = tms_q;

  assert_csc_takes_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_csc_i |=> csc_o == $past(wdata_i));

  assert_tms_takes_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tms_i |=> tms_o == $past(wdata_i));

  // R9: without a write to this slot both words hold
  assert_slot_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_csc_i || wr_tms_i) |=> ($stable(csc_o) && $stable(tms_o)));

endmodule

// File: rtl/mem_cfg_rdmux.sv
`timescale 1ns/1ps
module mem_cfg_rdmux
  import mem_cfg_pkg::*;
#(
  parameter int unsigned NUM_CS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_en_i,
  input  logic                     hit_i,
  input  logic                     sel_ctrl_i,
  input  logic                     sel_poc_i,
  input  logic                     sel_mask_i,
  input  logic [NUM_CS-1:0]        sel_csc_i,
  input  logic [NUM_CS-1:0]        sel_tms_i,
  input  logic [WORD_W-1:0]        ctrl_i,
  input  logic [WORD_W-1:0]        poc_i,
  input  logic [WORD_W-1:0]        mask_i,
  input  logic [NUM_CS*WORD_W-1:0] csc_i,
  input  logic [NUM_CS*WORD_W-1:0] tms_i,
  output logic [WORD_W-1:0]        rdata_o
);

  logic [WORD_W-1:0] mux;

  // AND-OR mux: selects are one-hot from the decoder
  always_comb begin
    mux = ({WORD_W{sel_ctrl_i}} & ctrl_i)
        | ({WORD_W{sel_poc_i}}  & poc_i)
        | ({WORD_W{sel_mask_i}} & mask_i);
    for (int i = 0; i < NUM_CS; i++) begin
      mux |= {WORD_W{sel_csc_i[i]}} & csc_i[i*WORD_W +: WORD_W];
      mux |= {WORD_W{sel_tms_i[i]}} & tms_i[i*WORD_W +: WORD_W];
    end
  end

  assign rdata_o = rd_en_i ? mux : '0;

  assert_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);

  assert_miss_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |-> rdata_o == '0);

endmodule

// File: rtl/mem_cfg_regs.sv
`timescale 1ns/1ps
module mem_cfg_regs
  import mem_cfg_pkg::*;
#(
  parameter int unsigned       NUM_CS     = 8,
  parameter int unsigned       AW         = 8,
  parameter logic [WORD_W-1:0] MASK_VALID = 32'h0000_00FF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [WORD_W-1:0]        poc_i,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic [WORD_W-1:0]        ctrl_o,
  output logic [WORD_W-1:0]        mask_o,
  output logic [NUM_CS*WORD_W-1:0] csc_o,
  output logic [NUM_CS*WORD_W-1:0] tms_o,
  output logic [NUM_CS-1:0]        upd_o
);

  logic              sel_ctrl, sel_poc, sel_mask, hit;
  logic [NUM_CS-1:0] sel_csc, sel_tms;
  logic              wr, rd;
  logic [NUM_CS-1:0] wr_csc, wr_tms, upd_d;
  logic [WORD_W-1:0] ctrl_q, mask_q, poc_q;
  logic [NUM_CS-1:0] upd_q;
  logic [NUM_CS-1:0][WORD_W-1:0] rst_csc, rst_tms;

  assign wr = req_i &&  we_i;
  assign rd = req_i && !we_i;

  mem_cfg_decode #(.AW(AW), .NUM_CS(NUM_CS)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .sel_ctrl_o (sel_ctrl),
    .sel_poc_o  (sel_poc),
    .sel_mask_o (sel_mask),
    .sel_csc_o  (sel_csc),
    .sel_tms_o  (sel_tms),
    .hit_o      (hit)
  );

  // strap word: captured while reset is held, frozen afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) poc_q <= poc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      upd_q  <= '0;
    end else begin
      if (wr && sel_ctrl) ctrl_q <= wdata_i;
      if (wr && sel_mask) mask_q <= wdata_i & MASK_VALID;
      upd_q <= upd_d;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
    if (i == 0) begin : g_boot
      assign rst_csc[i] = boot_csc(poc_i[3:0]);
      assign rst_tms[i] = boot_tms(poc_i[3:0]);
    end else begin : g_plain
      assign rst_csc[i] = '0;
      assign rst_tms[i] = '0;
    end

    assign wr_csc[i] = wr && sel_csc[i];
    assign wr_tms[i] = wr && sel_tms[i];
    assign upd_d[i]  = wr_csc[i] || wr_tms[i] || (wr && sel_mask);

    mem_cfg_cs_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rst_csc_i (rst_csc[i]),
      .rst_tms_i (rst_tms[i]),
      .wr_csc_i  (wr_csc[i]),
      .wr_tms_i  (wr_tms[i]),
      .wdata_i   (wdata_i),
      .csc_o     (csc_o[i*WORD_W +: WORD_W]),
      .tms_o     (tms_o[i*WORD_W +: WORD_W])
    );
  end

  mem_cfg_rdmux #(.NUM_CS(NUM_CS)) u_rdmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd),
    .hit_i      (hit),
    .sel_ctrl_i (sel_ctrl),
    .sel_poc_i  (sel_poc),
    .sel_mask_i (sel_mask),
    .sel_csc_i  (sel_csc),
    .sel_tms_i  (sel_tms),
    .ctrl_i     (ctrl_q),
    .poc_i      (poc_q),
    .mask_i     (mask_q),
    .csc_i      (csc_o),
    .tms_i      (tms_o),
    .rdata_o    (rdata_o)
  );

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  assign upd_o  = upd_q;

  assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_ctrl) |=> ctrl_o == $past(wdata_i));

  assert_poc_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_poc) |=> $stable(poc_q));

  assert_mask_valid_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~MASK_VALID) == '0);

  assert_mask_upd_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_mask) |=> &upd_o);

  assert_no_write_no_upd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> upd_o == '0);

  assert_miss_no_upd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !hit) |=> upd_o == '0);

endmodule

// File: tb/mem_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module mem_cfg_regs_tb_top;

  localparam int NCS = 8;
  localparam int AWB = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [31:0]       poc_i = '0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [AWB-1:0]    addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o, ctrl_o, mask_o;
  logic [NCS*32-1:0] csc_o, tms_o;
  logic [NCS-1:0]    upd_o;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [31:0]    m_ctrl, m_mask, m_poc;
  logic [31:0]    m_csc [NCS];
  logic [31:0]    m_tms [NCS];
  logic [NCS-1:0] m_upd;

  always #5 clk_i = ~clk_i;

  mem_cfg_regs #(.NUM_CS(NCS), .AW(AWB)) dut_i (
    .clk_i, .rst_ni, .poc_i, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .ctrl_o, .mask_o, .csc_o, .tms_o, .upd_o
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] def_tms(input int t);
    case (t)
      0: return 32'h03FF_FFFF;
      1: return 32'h0F20_0230;
      2: return 32'hFFFF_FFFF;
      default: return 32'h0000_3A5F;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int a);
    int w = a / 4;
    if (w == 0) return m_ctrl;
    if (w == 1) return m_poc;
    if (w == 2) return m_mask;
    if (w >= 4 && w < 4 + 2 * NCS) begin
      if ((w - 4) % 2 == 1) return m_tms[(w - 4) / 2];
      return m_csc[(w - 4) / 2];
    end
    return 32'h0;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    int w = a / 4;
    m_upd = '0;
    if (w == 0) m_ctrl = d;
    else if (w == 2) begin
      m_mask = d & 32'h0000_00FF;
      m_upd = '1;
    end else if (w >= 4 && w < 4 + 2 * NCS) begin
      if ((w - 4) % 2 == 1) m_tms[(w - 4) / 2] = d;
      else m_csc[(w - 4) / 2] = d;
      m_upd[(w - 4) / 2] = 1'b1;
    end
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " ctrl R2"}, 256'(ctrl_o), 256'(m_ctrl));
    chk({tag, " mask R4"}, 256'(mask_o), 256'(m_mask));
    chk({tag, " upd R10"}, 256'(upd_o), 256'(m_upd));
    for (int i = 0; i < NCS; i++) begin
      chk($sformatf("%s csc%0d R8", tag, i), 256'(csc_o[i*32 +: 32]), 256'(m_csc[i]));
      chk($sformatf("%s tms%0d R8", tag, i), 256'(tms_o[i*32 +: 32]), 256'(m_tms[i]));
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_write(input string tag, input int a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = AWB'(a); wdata_i = d;
    @(posedge clk_i); #1;
    model_write(a, d);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    check_outputs(tag);
    @(posedge clk_i); #1;
    m_upd = '0;
    @(negedge clk_i);
    check_outputs({tag, " after"});
  endtask

  task automatic do_read(input string tag, input int a);
    req_i = 1'b1; we_i = 1'b0; addr_i = AWB'(a);
    #1;
    chk({tag, " rdata R1"}, 256'(rdata_o), 256'(model_read(a)));
    @(negedge clk_i);
    req_i = 1'b0;
    #1;
    chk({tag, " idle rdata R11"}, 256'(rdata_o), 256'(0));
    check_outputs({tag, " post-read"});
  endtask

  task automatic do_reset(input logic [31:0] strap);
    rst_ni = 1'b0;
    poc_i = strap;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_ctrl = '0; m_mask = '0; m_upd = '0; m_poc = strap;
    for (int i = 0; i < NCS; i++) begin m_csc[i] = '0; m_tms[i] = '0; end
    m_csc[0] = (32'(strap[1:0]) << 4) | (32'(strap[3:2]) << 1) | 32'h1;
    m_tms[0] = def_tms(int'(strap[3:2]));
    check_outputs("reset R5 R6 R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    // R6, R7: boot values for every memory type
    for (int t = 0; t < 4; t++) begin
      do_reset(32'hA5C3_0000 | 32'(t << 2) | 32'((3 - t) & 3));
      do_read("boot csc0 R6", 16'h10);
      do_read("boot tms0 R7", 16'h14);
      do_read("strap R3", 16'h04);
    end
    // R3: strap frozen after reset
    poc_i = 32'h1111_1111;
    @(negedge clk_i);
    do_read("strap after pin change R3", 16'h04);
    do_write("poc write R3", 16'h04, 32'h1234_5678);
    do_read("poc after write R3", 16'h04);
    // R2
    do_write("ctrl write R2", 16'h00, 32'hDEAD_BEEF);
    do_read("ctrl read R2", 16'h00);
    // R4, R10
    do_write("mask write R4 R10", 16'h08, 32'hFFFF_FF5A);
    do_read("mask read R4", 16'h08);
    // R8, R10: each chip select, both words
    for (int i = 0; i < NCS; i++) begin
      do_write("csc write R8", 16'h10 + 8 * i, 32'h00C0_0031 + 32'(i << 16));
      do_write("tms write R8", 16'h14 + 8 * i, ~(32'h0101_0101 * 32'(i + 1)));
    end
    for (int i = 0; i < NCS; i++) begin
      do_read("csc read R1", 16'h10 + 8 * i);
      do_read("tms read R1", 16'h14 + 8 * i);
    end
    // R1: low address bits ignored
    do_write("lsb ignored R1", 16'h1B, 32'h5555_AAAA);
    do_read("lsb ignored read R1", 16'h1A);
    // R9: holes and beyond the map
    do_write("hole write R9", 16'h0C, 32'hFFFF_FFFF);
    do_write("past map write R9", 16'h10 + 8 * NCS, 32'hFFFF_FFFF);
    do_write("top write R9", 16'hFC, 32'hFFFF_FFFF);
    do_read("hole read R9", 16'h0C);
    do_read("past map read R9", 16'h50);
    do_read("top read R9", 16'hFC);
    // R11: address valid but no request
    addr_i = 8'h00; we_i = 1'b0; req_i = 1'b0;
    #1;
    chk("no request R11", 256'(rdata_o), 256'(0));
    @(negedge clk_i);
    // R5: reset after traffic clears everything except chip select 0 boot
    do_reset(32'h0000_0006);
    do_read("re-reset ctrl R5", 16'h00);
    do_read("re-reset csc3 R5", 16'h28);
    do_read("re-reset tms0 R7", 16'h14);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule